// File: doc/BRIEF.md
# Power-Management Control Register Target on I2C

This block is a serial-bus target that holds the seven control registers of a small power-management controller: two buck output-voltage codes, two linear-regulator output-voltage codes, a buck configuration byte, a system control byte and a slew-rate byte. It takes SCL and SDA that have already been synchronised to the system clock. It pulls SDA low through a single drive output and never drives it high.

A host writes registers by sending the device address with the write bit, then a register pointer, then any number of data bytes. The pointer advances after each byte. The host reads registers in one of two ways: it sets the pointer and issues a repeated START with the read bit, or it issues a read straight away and gets data from wherever the pointer stands. Every register is visible all the time as a parallel output to the regulator control logic.

Top module: `pmic_i2c_regs`

## Requirements
- R1: The target answers only to the 7-bit address 1101000, carried in bits 7..1 of the first byte after START, with bit 0 as the direction (0 write, 1 read). A matching address is ACKed by holding SDA low in the ninth clock. Any other address is NACKed, and the rest of that transaction is ignored (no ACKs, no writes) until the next START.
- R2: In a write, the byte after the address is the register pointer and each later byte is stored at the pointer. Each of these bytes is ACKed, the pointer advances after every data byte, and the stored value appears on the register's parallel output.
- R3: After a pointer write, a repeated START with the read bit returns register bytes MSB first, starting at the pointer and advancing after each byte.
- R4: A read with no pointer phase returns bytes starting at the current pointer, which is 0x00 after reset, and advances it after each byte.
- R5: A master NACK ends the read. SDA is released from that bit on and is not driven again before the next START.
- R6: The map is: buck 1 code at 0x00 (reset 0x0F), buck 2 code at 0x01 (reset 0x27), regulator 1 code at 0x02 (reset 0x30), regulator 2 code at 0x03 (reset 0x0C), buck configuration at 0x04 (reset 0x0F), system control at 0x05 (reset 0x4F) and slew control at 0x06 (reset 0x22). Each register drives its own output port.
- R7: Reserved bits read as 0, show as 0 on the outputs and ignore writes. The writable masks are 0x7F for 0x00, 0x01, 0x04 and 0x05, 0x3F for 0x02 and 0x03, and 0xEE for 0x06.
- R8: Advancing the pointer from 0x06 gives 0x00, in both writes and reads.
- R9: With the pointer at 0x07 or above, data bytes are still ACKed but are discarded, and reads return 0x00.
- R10: A STOP or START that arrives before all eight bits of a byte have been received discards that byte. No register changes and the pointer does not move.
- R11: SDA is only ever pulled low. The drive output changes only after an SCL falling edge, a START or a STOP, and it is released whenever the bus is idle after a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised serial clock |
| sda_in | input | 1 | Synchronised serial data (bus level) |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| buck1_vsel | output | 8 | Register 0x00 contents |
| buck2_vsel | output | 8 | Register 0x01 contents |
| ldo1_vsel | output | 8 | Register 0x02 contents |
| ldo2_vsel | output | 8 | Register 0x03 contents |
| buck_cfg | output | 8 | Register 0x04 contents |
| sys_cfg | output | 8 | Register 0x05 contents |
| slew_cfg | output | 8 | Register 0x06 contents |

## Verification
The bench drives the following traffic:
- **Pointer-prefixed and bare reads.** Both start from the reset pointer and from pointers left behind by earlier traffic, which separates the pointer-load path from the pointer-advance path.
- **Random bursts.** Writes and reads of random length start at pointers from 0x00 to 0x08. Bursts that cross 0x06 expose a wrong wrap, and bursts that start above the map expose data that leaks into real registers.
- **All-ones write.** This isolates the reserved-bit masks.
- **Foreign-address transactions.** These distinguish a target that ignores the whole transaction from one that only skips the address ACK.
- **Bytes cut short by STOP or by a repeated START.** These show whether a partial byte can reach a register or move the pointer.

// File: rtl/pmic_i2c_pkg.sv
package pmic_i2c_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_REGS = 7;
    localparam int PTR_W    = 8;
    localparam logic [6:0] DEV_ADDR = 7'b1101000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } rx_phase_e;

    function automatic logic [REG_W-1:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'h0F;
            1:       return 8'h27;
            2:       return 8'h30;
            3:       return 8'h0C;
            4:       return 8'h0F;
            5:       return 8'h4F;
            6:       return 8'h22;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] reg_mask(input int idx);
        case (idx)
            0, 1, 4, 5: return 8'h7F;
            2, 3:       return 8'h3F;
            6:          return 8'hEE;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [NUM_REGS*REG_W-1:0] reset_image();
        logic [NUM_REGS*REG_W-1:0] img;
        img = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            img[i*REG_W +: REG_W] = reg_reset(i);
        end
        return img;
    endfunction

endpackage

// File: rtl/bus_cond_det.sv
module bus_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d.scl = scl_in;
        line_d.sda = sda_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '1;
        end else begin
            line_q <= line_d;
        end
    end

    assign scl_rise = !line_q.scl && scl_in;
    assign scl_fall = line_q.scl && !scl_in;
    assign start_ev = line_q.scl && scl_in && line_q.sda && !sda_in;
    assign stop_ev  = line_q.scl && scl_in && !line_q.sda && sda_in;

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import pmic_i2c_pkg::*;
#(
    parameter int NUM = NUM_REGS,
    parameter int W   = REG_W,
    parameter int AW  = PTR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [W-1:0]   wdata,
    input  logic [AW-1:0]  raddr,
    output logic [W-1:0]   rdata,
    output logic [NUM*W-1:0] image
);
    localparam int IW = $clog2(NUM);
    localparam logic [NUM*W-1:0] RST_IMG = (NUM*W)'(reset_image());

    logic [NUM*W-1:0] image_d, image_q;

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        localparam logic [W-1:0] MSK = W'(reg_mask(g));
        assign image_d[g*W +: W] = (we && waddr == AW'(g)) ? (wdata & MSK)
                                                            : image_q[g*W +: W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            image_q <= RST_IMG;
        end else begin
            image_q <= image_d;
        end
    end

    assign rdata = (raddr < AW'(NUM)) ? image_q[raddr[IW-1:0]*W +: W] : '0;
    assign image = image_q;

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr < AW'(NUM)) |=>
            image_q[$past(waddr[IW-1:0])*W +: W] ==
                ($past(wdata) & W'(reg_mask(int'($past(waddr))))));

    assert_outside_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr >= AW'(NUM)) |=> $stable(image_q));

    assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(image_q));

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import pmic_i2c_pkg::*;
#(
    parameter int NUM = NUM_REGS,
    parameter int W   = REG_W,
    parameter int AW  = PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic          sda_in,
    input  logic [W-1:0]  rd_data,
    output logic          sda_pull,
    output logic          reg_we,
    output logic [AW-1:0] reg_ptr,
    output logic [W-1:0]  reg_wdata
);
    localparam int CW = $clog2(W) + 1;

    typedef struct packed {
        bus_state_e    st;
        rx_phase_e     ph;
        logic [CW-1:0] cnt;
        logic [W-1:0]  sh;
        logic [AW-1:0] ptr;
        logic          drive;
        logic          rw;
    } fsm_t;

    fsm_t q, d;
    logic we_c;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(NUM - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d    = q;
        we_c = 1'b0;
        if (stop_ev) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
            d.cnt   = '0;
        end else if (start_ev) begin
            d.st    = ST_RX;
            d.ph    = PH_ADDR;
            d.cnt   = '0;
            d.drive = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt < CW'(W)) begin
                        d.sh  = {q.sh[W-2:0], sda_in};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CW'(W)) begin
                        d.cnt = '0;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.rw    = q.sh[0];
                                    d.drive = 1'b1;
                                    d.st    = ST_RX_ACK;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            PH_PTR: begin
                                d.ptr   = q.sh;
                                d.ph    = PH_DATA;
                                d.drive = 1'b1;
                                d.st    = ST_RX_ACK;
                            end
                            default: begin
                                we_c    = 1'b1;
                                d.ptr   = ptr_next(q.ptr);
                                d.drive = 1'b1;
                                d.st    = ST_RX_ACK;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.ph == PH_ADDR && q.rw) begin
                            d.sh    = rd_data;
                            d.ptr   = ptr_next(q.ptr);
                            d.drive = !rd_data[W-1];
                            d.st    = ST_TX;
                        end else begin
                            d.drive = 1'b0;
                            d.st    = ST_RX;
                            if (q.ph == PH_ADDR) begin
                                d.ph = PH_PTR;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == CW'(W - 1)) begin
                            d.drive = 1'b0;
                            d.st    = ST_TX_ACK;
                        end else begin
                            d.sh    = {q.sh[W-2:0], 1'b0};
                            d.drive = !q.sh[W-2];
                            d.cnt   = q.cnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise && sda_in) begin
                        d.st = ST_IDLE;
                    end else if (scl_fall) begin
                        d.sh    = rd_data;
                        d.ptr   = ptr_next(q.ptr);
                        d.drive = !rd_data[W-1];
                        d.cnt   = '0;
                        d.st    = ST_TX;
                    end
                end
                default: begin
                    d.drive = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.ph    <= PH_ADDR;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.ptr   <= '0;
            q.drive <= 1'b0;
            q.rw    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_pull  = q.drive;
    assign reg_we    = we_c;
    assign reg_ptr   = q.ptr;
    assign reg_wdata = q.sh;

    assert_drive_edges_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall || start_ev || stop_ev));

    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_pull);

    assert_foreign_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RX && q.ph == PH_ADDR && scl_fall && q.cnt == CW'(W) &&
         q.sh[7:1] != DEV_ADDR && !start_ev && !stop_ev) |=> !sda_pull);

    assert_nack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TX_ACK && scl_rise && sda_in && !stop_ev && !start_ev)
            |=> (!sda_pull && q.st == ST_IDLE));

    assert_abort_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RX && q.cnt != CW'(W)) |-> !reg_we);

endmodule

// File: rtl/pmic_i2c_regs.sv
module pmic_i2c_regs
    import pmic_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    output logic [7:0] buck1_vsel,
    output logic [7:0] buck2_vsel,
    output logic [7:0] ldo1_vsel,
    output logic [7:0] ldo2_vsel,
    output logic [7:0] buck_cfg,
    output logic [7:0] sys_cfg,
    output logic [7:0] slew_cfg
);
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic reg_we;
    logic [PTR_W-1:0] reg_ptr;
    logic [REG_W-1:0] reg_wdata, rd_data;
    logic [NUM_REGS*REG_W-1:0] image;

    bus_cond_det u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_target_fsm #(.NUM(NUM_REGS), .W(REG_W), .AW(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .sda_in    (sda_in),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull),
        .reg_we    (reg_we),
        .reg_ptr   (reg_ptr),
        .reg_wdata (reg_wdata)
    );

    ctl_regfile #(.NUM(NUM_REGS), .W(REG_W), .AW(PTR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_ptr),
        .wdata (reg_wdata),
        .raddr (reg_ptr),
        .rdata (rd_data),
        .image (image)
    );

    assign buck1_vsel = image[0*REG_W +: REG_W];
    assign buck2_vsel = image[1*REG_W +: REG_W];
    assign ldo1_vsel  = image[2*REG_W +: REG_W];
    assign ldo2_vsel  = image[3*REG_W +: REG_W];
    assign buck_cfg   = image[4*REG_W +: REG_W];
    assign sys_cfg    = image[5*REG_W +: REG_W];
    assign slew_cfg   = image[6*REG_W +: REG_W];

endmodule

// File: tb/sim_pmic_i2c_regs.sv
module sim_pmic_i2c_regs;
    localparam int Q = 4;
    localparam logic [7:0] ADDR_W = 8'hD0;
    localparam logic [7:0] ADDR_R = 8'hD1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [7:0] p0, p1, p2, p3, p4, p5, p6;
    wire sda_line = sda_m & ~sda_pull;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] mem [7];
    logic [7:0] mptr;

    always #4 clk = ~clk;

    pmic_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .buck1_vsel(p0), .buck2_vsel(p1), .ldo1_vsel(p2),
        .ldo2_vsel(p3), .buck_cfg(p4), .sys_cfg(p5), .slew_cfg(p6)
    );

    function automatic logic [7:0] bmask(int i);
        case (i)
            2, 3:    return 8'h3F;
            6:       return 8'hEE;
            default: return 8'h7F;
        endcase
    endfunction

    function automatic logic [7:0] breset(int i);
        case (i)
            0: return 8'h0F; 1: return 8'h27; 2: return 8'h30; 3: return 8'h0C;
            4: return 8'h0F; 5: return 8'h4F; default: return 8'h22;
        endcase
    endfunction

    function automatic logic [7:0] pnext(logic [7:0] p);
        return (p == 8'h06) ? 8'h00 : p + 8'h01;
    endfunction

    function automatic logic [7:0] port_val(int i);
        case (i)
            0: return p0; 1: return p1; 2: return p2; 3: return p3;
            4: return p4; 5: return p5; default: return p6;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_ports(input string req);
        for (int i = 0; i < 7; i++) chk(req, port_val(i), mem[i]);
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 0; hold(Q); scl_m = 0; hold(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1; hold(Q); scl_m = 1; hold(Q); sda_m = 0; hold(Q); scl_m = 0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; hold(Q); scl_m = 1; hold(Q); sda_m = 1; hold(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; hold(Q); scl_m = 1; hold(2*Q); scl_m = 0; hold(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1; hold(Q); scl_m = 1; hold(Q); b = sda_line; hold(Q); scl_m = 0; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            get_bit(s);
            v[i] = s;
        end
        put_bit(last);
    endtask

    task automatic wr_burst(input logic [7:0] ra, input int n, input bit rnd, input logic [7:0] fixed);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte(ADDR_W, ack); chk("R1", ack, 1);
        send_byte(ra, ack);     chk("R2", ack, 1);
        mptr = ra;
        for (int i = 0; i < n; i++) begin
            v = rnd ? 8'($urandom) : fixed;
            send_byte(v, ack);
            chk(mptr < 7 ? "R2" : "R9", ack, 1);
            if (mptr < 7) mem[mptr] = v & bmask(int'(mptr));
            mptr = pnext(mptr);
        end
        bus_stop();
        check_ports("R2");
        chk("R11", sda_pull, 0);
    endtask

    task automatic rd_burst(input bit with_ptr, input logic [7:0] ra, input int n, input string req);
        logic ack;
        logic [7:0] v, e;
        bus_start();
        if (with_ptr) begin
            send_byte(ADDR_W, ack); chk("R1", ack, 1);
            send_byte(ra, ack);     chk("R3", ack, 1);
            mptr = ra;
            bus_rstart();
        end
        send_byte(ADDR_R, ack); chk("R1", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, v);
            e = (mptr < 7) ? mem[mptr] : 8'h00;
            chk(req, v, e);
            mptr = pnext(mptr);
        end
        chk("R5", sda_pull, 0);
        bus_stop();
        chk("R11", sda_pull, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 7; i++) mem[i] = breset(i);
        mptr = 8'h00;
        hold(5);
        rst_n = 1;
        hold(5);

        // R6: reset image on the outputs
        check_ports("R6");
        chk("R11", sda_pull, 0);
        // R4: bare read from reset pointer, then R8 wrap while reading
        rd_burst(0, 8'h00, 3, "R4");
        rd_burst(0, 8'h00, 6, "R8");
        // R7: all-ones write leaves reserved bits clear
        wr_burst(8'h00, 7, 0, 8'hFF);
        check_ports("R7");
        rd_burst(1, 8'h00, 7, "R7");
        // R8: write burst wrapping past 0x06
        wr_burst(8'h05, 4, 1, 8'h00);
        check_ports("R8");
        rd_burst(1, 8'h05, 4, "R3");
        // R9: out-of-map pointer
        wr_burst(8'h09, 2, 1, 8'h00);
        check_ports("R9");
        rd_burst(1, 8'h0A, 2, "R9");
        // R1: foreign address, write and read direction
        bus_start();
        send_byte(8'hA0, ack); chk("R1", ack, 0);
        send_byte(8'h00, ack); chk("R1", ack, 0);
        send_byte(8'h55, ack); chk("R1", ack, 0);
        bus_stop();
        check_ports("R1");
        bus_start();
        send_byte(8'h51, ack); chk("R1", ack, 0);
        bus_stop();
        chk("R1", sda_pull, 0);
        // R10: STOP mid-byte
        bus_start();
        send_byte(ADDR_W, ack); chk("R1", ack, 1);
        send_byte(8'h02, ack);  chk("R2", ack, 1);
        mptr = 8'h02;
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        check_ports("R10");
        rd_burst(0, 8'h00, 1, "R10");
        // R10: repeated START mid-byte, pointer must not move
        bus_start();
        send_byte(ADDR_W, ack); chk("R1", ack, 1);
        send_byte(8'h03, ack);  chk("R2", ack, 1);
        mptr = 8'h03;
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        bus_rstart();
        send_byte(ADDR_R, ack); chk("R1", ack, 1);
        recv_byte(1'b1, v);
        chk("R10", v, mem[3]);
        mptr = pnext(mptr);
        bus_stop();
        check_ports("R10");

        // random traffic
        for (int t = 0; t < 30; t++) begin
            int op, n;
            logic [7:0] ra;
            op = int'($urandom % 3);
            ra = 8'($urandom % 9);
            n  = 1 + int'($urandom % 5);
            case (op)
                0: wr_burst(ra, n, 1, 8'h00);
                1: rd_burst(1, ra, n, "R3");
                default: rd_burst(0, 8'h00, n, "R4");
            endcase
        end
        check_ports("R2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule